// File: doc/BRIEF.md
# Write-Protect Configuration Command Decoder

This block sits behind the byte engine of an I2C slave in a serial EEPROM model. It follows the bytes a master writes after a Start condition and spots the one sequence that programs or reads back the write-protect window. A write transfer whose first address byte has its top bit set is taken as a configuration command and is never treated as an array write. The window is described by two numbers: the index of the first protected block and the number of protected blocks.

For each received byte, the block reports whether the device acknowledges it. During a read-back it supplies the two bytes to be shifted out. It holds the committed window in flops, which reset to the factory values. Once a non-zero block count has been committed, the window is locked. Later program commands are then accepted on the bus but have no effect.

The byte engine signals Start, Stop, each received byte, and each transmitted byte together with the master's acknowledge bit. The array controller reads the committed window from `prot_start` and `prot_count`.

Top module: `secure_cfg_ctl`

## Requirements
- R1: After reset, `prot_start` is 15, `prot_count` is 0, `cfg_locked` is 0, and `ack_valid` and `tx_valid` are 0.
- R2: Every received byte produces `ack_valid` high for one cycle, on the clock edge that samples `rx_valid`. The first byte after Start is acknowledged (`ack`=1) only if bits 7..1 equal the device address 0x50 and bit 0 (read/write) is 0; the full byte is 0xA0.
- R3: An acknowledged first address byte with bit 7 set starts a configuration command. With bit 7 clear, that byte and every later byte up to the next Start are not acknowledged by this block.
- R4: The second byte after the control byte is acknowledged whatever its value.
- R5: If the third byte has bit 7 clear, it is not acknowledged, and the configuration is unchanged when Stop follows.
- R6: A program command has a third byte with bit 7 = 1 and bit 6 = 0. Its new start index is bits 4..1 of the first address byte (bits 0, 5 and 6 ignored). Its new count is bits 3..0 of the third byte (bits 5 and 4 ignored). The third byte is acknowledged. The outputs change only on the edge that samples Stop.
- R7: A program command cut short by Stop, or by a repeated Start, before its third byte leaves the configuration unchanged.
- R8: While `prot_count` is non-zero, `cfg_locked` is 1. A program command is then still acknowledged but changes nothing.
- R9: A program command with count 0, issued while unlocked, updates the start index and leaves the block unlocked and programmable again.
- R10: A third byte with bit 7 = 1 and bit 6 = 1 is acknowledged and starts a read-back. `tx_valid` goes high with `tx_data` = {1111, start}. On `tx_done` with `tx_mack`=1 it switches to {1111, count}. On `tx_done` with `tx_mack`=0, or after the second byte, `tx_valid` goes low.
- R11: A byte received after the third byte of a program command is not acknowledged, and it cancels the pending update.
- R12: Stop or Start ends a read-back: `tx_valid` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated Start seen (one-cycle strobe) |
| bus_stop | input | 1 | Stop seen (one-cycle strobe) |
| rx_valid | input | 1 | A byte written by the master is complete |
| rx_data | input | 8 | The received byte |
| tx_done | input | 1 | A read-back byte has been shifted out |
| tx_mack | input | 1 | The master's acknowledge for that byte (1 = ACK) |
| ack_valid | output | 1 | Acknowledge decision available for the last byte |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| tx_valid | output | 1 | A read-back byte is presented |
| tx_data | output | 8 | Read-back byte |
| prot_start | output | BLK_W | Committed first protected block |
| prot_count | output | BLK_W | Committed number of protected blocks |
| cfg_locked | output | 1 | Window is locked against reprogramming |

## Verification
The stimulus covers the following cases. A wrong device address and a read control byte tell address matching apart from direction checking. A first address byte with bit 7 clear separates configuration traffic from array traffic. Sequences that end early by Stop or by a repeated Start, and a program command followed by an extra byte, show that only a clean Stop after the third byte commits. A zero-count program and then a locking program, followed by a program attempt while locked, separate repeatable programming from the one-time lock. Read-backs are ended by a master ACK then NACK, by an early NACK, and by an early Stop, which checks both returned bytes and each way the transmission can end.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_PAD,
      ST_OPC,
      ST_SEND_A,
      ST_SEND_B,
      ST_SKIP,
      ST_ARMED
   } seq_st_t;

endpackage

// File: rtl/seccfg_seq.sv
module seccfg_seq
   import sec_cfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR   = 7'h50,
   parameter bit         ACK_LOCKED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              tx_done,
   input  logic              tx_mack,
   input  logic              locked,
   output seq_st_t           state,
   output logic              ack_valid,
   output logic              ack,
   output logic              cap_start,
   output logic              cap_count,
   output logic              commit
);

   seq_st_t state_q, state_d;
   logic    ack_d;
   logic    prog_ack;

   // R8: a program command seen while locked may be acknowledged or refused
   generate
      if (ACK_LOCKED) begin : g_ack_always
         assign prog_ack = 1'b1;
      end else begin : g_ack_unlocked
         assign prog_ack = ~locked;
      end
   endgenerate

   always_comb begin
      state_d   = state_q;
      ack_d     = 1'b0;
      cap_start = 1'b0;
      cap_count = 1'b0;
      commit    = 1'b0;
      if (bus_stop) begin
         // R6 R7 R11: only an armed command commits, and only while unlocked
         commit  = (state_q == ST_ARMED) && !locked;
         state_d = ST_IDLE;
      end else if (bus_start) begin
         state_d = ST_CTRL;
      end else if (rx_valid) begin
         unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_CTRL: begin
               // R2
               if (rx_data[7:1] == DEV_ADDR && !rx_data[0]) begin
                  ack_d   = 1'b1;
                  state_d = ST_ADDR;
               end else begin
                  state_d = ST_SKIP;
               end
            end
            ST_ADDR: begin
               // R3
               if (rx_data[7]) begin
                  ack_d     = 1'b1;
                  cap_start = 1'b1;
                  state_d   = ST_PAD;
               end else begin
                  state_d = ST_SKIP;
               end
            end
            ST_PAD: begin
               // R4
               ack_d   = 1'b1;
               state_d = ST_OPC;
            end
            ST_OPC: begin
               if (!rx_data[7]) begin
                  state_d = ST_SKIP;          // R5
               end else if (rx_data[6]) begin
                  ack_d   = 1'b1;             // R10
                  state_d = ST_SEND_A;
               end else begin
                  ack_d     = prog_ack;       // R6
                  cap_count = 1'b1;
                  state_d   = ST_ARMED;
               end
            end
            default: state_d = ST_SKIP;       // R11
         endcase
      end else if (tx_done) begin
         if (state_q == ST_SEND_A) begin
            state_d = tx_mack ? ST_SEND_B : ST_SKIP;
         end else if (state_q == ST_SEND_B) begin
            state_d = ST_SKIP;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ack_valid <= 1'b0;
         ack       <= 1'b0;
      end else begin
         state_q   <= state_d;
         ack_valid <= rx_valid && !bus_start && !bus_stop;
         ack       <= ack_d;
      end
   end

   assign state = state_q;

endmodule

// File: rtl/seccfg_store.sv
module seccfg_store #(
   parameter int BLK_W     = 4,
   parameter int DEF_START = 15,
   parameter int DEF_COUNT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_start,
   input  logic             cap_count,
   input  logic [BLK_W-1:0] start_field,
   input  logic [BLK_W-1:0] count_field,
   input  logic             commit,
   output logic [BLK_W-1:0] prot_start,
   output logic [BLK_W-1:0] prot_count,
   output logic             locked
);

   localparam logic [BLK_W-1:0] RST_START = BLK_W'(DEF_START);
   localparam logic [BLK_W-1:0] RST_COUNT = BLK_W'(DEF_COUNT);

   logic [BLK_W-1:0] pend_start, pend_count;
   logic [BLK_W-1:0] start_q, count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_start <= RST_START;
         pend_count <= RST_COUNT;
      end else begin
         if (cap_start) pend_start <= start_field;
         if (cap_count) pend_count <= count_field;
      end
   end

   // R1 R6 R9
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= RST_START;
         count_q <= RST_COUNT;
      end else if (commit) begin
         start_q <= pend_start;
         count_q <= pend_count;
      end
   end

   assign prot_start = start_q;
   assign prot_count = count_q;
   assign locked     = |count_q;   // R8

endmodule

// File: rtl/seccfg_txmux.sv
module seccfg_txmux
   import sec_cfg_pkg::*;
#(
   parameter int BLK_W = 4
) (
   input  seq_st_t           state,
   input  logic [BLK_W-1:0]  prot_start,
   input  logic [BLK_W-1:0]  prot_count,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data
);

   localparam int PAD_W = BYTE_W - BLK_W;

   logic [BLK_W-1:0] field;

   // R10
   assign tx_valid = (state == ST_SEND_A) || (state == ST_SEND_B);
   assign field    = (state == ST_SEND_B) ? prot_count : prot_start;
   assign tx_data  = {{PAD_W{1'b1}}, field};

endmodule

// File: rtl/secure_cfg_ctl.sv
module secure_cfg_ctl
   import sec_cfg_pkg::*;
#(
   parameter int         BLK_W      = 4,
   parameter logic [6:0] DEV_ADDR   = 7'h50,
   parameter int         DEF_START  = (1 << BLK_W) - 1,
   parameter int         DEF_COUNT  = 0,
   parameter bit         ACK_LOCKED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             tx_done,
   input  logic             tx_mack,
   output logic             ack_valid,
   output logic             ack,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic [BLK_W-1:0] prot_start,
   output logic [BLK_W-1:0] prot_count,
   output logic             cfg_locked
);

   generate
      if (BLK_W < 1 || BLK_W > 4) begin : g_bad_width
         $error("secure_cfg_ctl: BLK_W must lie in 1..4");
      end
      if (DEF_START < 0 || DEF_START >= (1 << BLK_W)) begin : g_bad_start
         $error("secure_cfg_ctl: DEF_START out of range");
      end
      if (DEF_COUNT < 0 || DEF_COUNT >= (1 << BLK_W)) begin : g_bad_count
         $error("secure_cfg_ctl: DEF_COUNT out of range");
      end
   endgenerate

   seq_st_t state;
   logic    cap_start, cap_count, commit;

   seccfg_seq #(
      .DEV_ADDR   (DEV_ADDR),
      .ACK_LOCKED (ACK_LOCKED)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_start (bus_start),
      .bus_stop  (bus_stop),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .tx_done   (tx_done),
      .tx_mack   (tx_mack),
      .locked    (cfg_locked),
      .state     (state),
      .ack_valid (ack_valid),
      .ack       (ack),
      .cap_start (cap_start),
      .cap_count (cap_count),
      .commit    (commit)
   );

   seccfg_store #(
      .BLK_W     (BLK_W),
      .DEF_START (DEF_START),
      .DEF_COUNT (DEF_COUNT)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_start   (cap_start),
      .cap_count   (cap_count),
      .start_field (rx_data[BLK_W:1]),
      .count_field (rx_data[BLK_W-1:0]),
      .commit      (commit),
      .prot_start  (prot_start),
      .prot_count  (prot_count),
      .locked      (cfg_locked)
   );

   seccfg_txmux #(
      .BLK_W (BLK_W)
   ) u_tx (
      .state      (state),
      .prot_start (prot_start),
      .prot_count (prot_count),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data)
   );

endmodule

// File: rtl/seccfg_chk.sv
module seccfg_chk #(
   parameter int BLK_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_stop,
   input logic             rx_valid,
   input logic             ack_valid,
   input logic             ack,
   input logic             tx_valid,
   input logic [7:0]       tx_data,
   input logic [BLK_W-1:0] prot_start,
   input logic [BLK_W-1:0] prot_count,
   input logic             cfg_locked
);

   // R2
   ack_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ack_valid);

   // R2
   ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(rx_valid));

   // R6
   cfg_moves_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_start != $past(prot_start) || prot_count != $past(prot_count)) |-> $past(bus_stop));

   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_locked) |-> ($stable(prot_start) && $stable(prot_count)));

   // R10
   tx_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (&tx_data[7:BLK_W]));

   // R12
   tx_ends_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_stop) |-> !tx_valid);

endmodule

bind secure_cfg_ctl seccfg_chk #(.BLK_W(BLK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_stop   (bus_stop),
   .rx_valid   (rx_valid),
   .ack_valid  (ack_valid),
   .ack        (ack),
   .tx_valid   (tx_valid),
   .tx_data    (tx_data),
   .prot_start (prot_start),
   .prot_count (prot_count),
   .cfg_locked (cfg_locked)
);

// File: tb/test_secure_cfg_ctl.sv
`timescale 1ns/1ps
module test_secure_cfg_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       tx_done = 1'b0, tx_mack = 1'b0;
   logic       ack_valid, ack, tx_valid, cfg_locked;
   logic [7:0] tx_data;
   logic [3:0] prot_start, prot_count;

   int  n_run = 0, n_fail = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   secure_cfg_ctl i_secure_cfg_ctl (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_done(tx_done), .tx_mack(tx_mack),
      .ack_valid(ack_valid), .ack(ack), .tx_valid(tx_valid), .tx_data(tx_data),
      .prot_start(prot_start), .prot_count(prot_count), .cfg_locked(cfg_locked)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: phase numbers 0 idle, 1 control, 2 address,
   // 3 filler, 4 opcode, 5 first return, 6 second return, 7 ignore, 8 armed
   int m_ph = 0, m_st = 15, m_cnt = 0, m_ps = 15, m_pc = 0, m_av = 0, m_ack = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_st = 15; m_cnt = 0; m_ps = 15; m_pc = 0; m_av = 0; m_ack = 0;
      end else begin
         m_av = 0; m_ack = 0;
         if (bus_stop) begin
            if (m_ph == 8 && m_cnt == 0) begin m_st = m_ps; m_cnt = m_pc; end
            m_ph = 0;
         end else if (bus_start) begin
            m_ph = 1;
         end else if (rx_valid) begin
            m_av = 1;
            case (m_ph)
               0: m_ph = 0;
               1: if (rx_data == 8'hA0) begin m_ack = 1; m_ph = 2; end else m_ph = 7;
               2: if (rx_data[7]) begin m_ack = 1; m_ps = (int'(rx_data) >> 1) & 15; m_ph = 3; end
                  else m_ph = 7;
               3: begin m_ack = 1; m_ph = 4; end
               4: if (!rx_data[7]) m_ph = 7;
                  else begin
                     m_ack = 1;
                     if (rx_data[6]) m_ph = 5;
                     else begin m_pc = int'(rx_data) & 15; m_ph = 8; end
                  end
               default: m_ph = 7;
            endcase
         end else if (tx_done) begin
            if (m_ph == 5) m_ph = tx_mack ? 6 : 7;
            else if (m_ph == 6) m_ph = 7;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2", "model ack_valid", int'(ack_valid), m_av);
         chk("R2", "model ack", int'(ack), m_ack);
         chk("R10", "model tx_valid", int'(tx_valid), int'(m_ph == 5 || m_ph == 6));
         if (tx_valid)
            chk("R10", "model tx_data", int'(tx_data), 8'hF0 | ((m_ph == 6) ? m_cnt : m_st));
         chk("R6", "model prot_start", int'(prot_start), m_st);
         chk("R6", "model prot_count", int'(prot_count), m_cnt);
         chk("R8", "model cfg_locked", int'(cfg_locked), int'(m_cnt != 0));
      end
   end

   task automatic send(input logic [7:0] b, output bit a);
      @(negedge clk); rx_data = b; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0; a = ack;
   endtask
   task automatic do_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
   endtask
   task automatic do_stop();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask
   task automatic take(input bit m);
      @(negedge clk); tx_done = 1'b1; tx_mack = m;
      @(negedge clk); tx_done = 1'b0; tx_mack = 1'b0;
   endtask
   task automatic cfg_head(input logic [7:0] a1, output bit a);
      bit t;
      do_start();
      send(8'hA0, t);
      send(a1, a);
      send(8'h5A, t);
   endtask

   initial begin
      bit a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1", "reset start", int'(prot_start), 15);
      chk("R1", "reset count", int'(prot_count), 0);
      chk("R1", "reset locked", int'(cfg_locked), 0);
      chk("R1", "reset tx_valid", int'(tx_valid), 0);
      chk("R1", "reset ack_valid", int'(ack_valid), 0);

      // R2: wrong address, then read direction
      do_start(); send(8'hA2, a); chk("R2", "wrong address ack", int'(a), 0);
      send(8'h80, a); chk("R3", "byte after rejected control", int'(a), 0);
      do_stop();
      do_start(); send(8'hA1, a); chk("R2", "read control ack", int'(a), 0);
      do_stop();

      // R3: array address, not configuration
      do_start(); send(8'hA0, a); chk("R2", "good control ack", int'(a), 1);
      send(8'h12, a); chk("R3", "array address ack", int'(a), 0);
      send(8'h83, a); chk("R3", "later byte ack", int'(a), 0);
      do_stop();

      // R5: third byte with bit 7 clear
      cfg_head(8'h88, a); chk("R3", "config address ack", int'(a), 1);
      send(8'h05, a); chk("R5", "bad opcode ack", int'(a), 0);
      do_stop();
      chk("R5", "start unchanged", int'(prot_start), 15);
      chk("R5", "count unchanged", int'(prot_count), 0);

      // R9 R4: zero-count program with ignored address bits set
      do_start(); send(8'hA0, a); send(8'hE9, a);
      send(8'h00, a); chk("R4", "filler ack", int'(a), 1);
      send(8'h80, a); chk("R6", "program ack", int'(a), 1);
      do_stop();
      chk("R9", "start programmed", int'(prot_start), 4);
      chk("R9", "still unlocked", int'(cfg_locked), 0);

      // R7: Stop before third byte, and repeated Start
      cfg_head(8'h8A, a); do_stop();
      chk("R7", "stop early start", int'(prot_start), 4);
      cfg_head(8'h8A, a); send(8'h83, a); do_start(); do_stop();
      chk("R7", "restart start", int'(prot_start), 4);
      chk("R7", "restart count", int'(prot_count), 0);

      // R11: extra byte cancels
      cfg_head(8'h8A, a); send(8'h83, a); send(8'h00, a);
      chk("R11", "extra byte ack", int'(a), 0);
      do_stop();
      chk("R11", "count unchanged", int'(prot_count), 0);

      // R6: locking program
      cfg_head(8'h8A, a); send(8'hB3, a); chk("R6", "program ack", int'(a), 1);
      chk("R6", "no change before stop", int'(prot_start), 4);
      do_stop();
      chk("R6", "start committed", int'(prot_start), 5);
      chk("R6", "count committed", int'(prot_count), 3);
      chk("R8", "locked", int'(cfg_locked), 1);

      // R8: program while locked
      cfg_head(8'h9E, a); send(8'h87, a); chk("R8", "locked program ack", int'(a), 1);
      do_stop();
      chk("R8", "start kept", int'(prot_start), 5);
      chk("R8", "count kept", int'(prot_count), 3);

      // R10: full read-back
      cfg_head(8'h80, a); send(8'hC0, a); chk("R10", "readback ack", int'(a), 1);
      chk("R10", "first byte", int'(tx_data), 8'hF5);
      take(1'b1);
      chk("R10", "second byte", int'(tx_data), 8'hF3);
      take(1'b0);
      chk("R10", "tx ends", int'(tx_valid), 0);
      do_stop();

      // R10: master refuses the first byte
      cfg_head(8'h80, a); send(8'hF0, a); take(1'b0);
      chk("R10", "early nack ends", int'(tx_valid), 0);
      do_stop();

      // R12: Stop during read-back
      cfg_head(8'h80, a); send(8'hC0, a);
      chk("R12", "tx before stop", int'(tx_valid), 1);
      do_stop();
      chk("R12", "tx after stop", int'(tx_valid), 0);

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL R1 watchdog actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule